// File: doc/BRIEF.md
# UART Receive/Transmit Ready Pin Generator

This block drives the two active-low service-request pins of one UART channel: a receive-ready pin that asks for the receive buffer to be read, and a transmit-ready pin that asks for the transmit buffer to be written. It takes the buffer occupancy counts, a trigger-level flag, a receive-timeout flag and two mode bits. The buffers, the trigger-level selection and the timeout counter all live elsewhere.

The two mode bits select one of three pin laws. When the buffers are disabled, the channel behaves as a single holding register in each direction. When the buffers are enabled without burst transfer, the pins report "anything to read" and "transmit side drained". In burst-transfer mode the transmit pin reports free space. In the same mode the receive pin becomes hysteretic: it asserts when the buffer fills to the trigger level or a timeout occurs, and it releases only when the buffer has been read empty. This lets a DMA engine move a whole burst per request.

Both pins are registered, so each one reflects the inputs one clock earlier.

Top module: `uart_dma_rdy`

## Requirements
- R1: During synchronous reset (`rst_n` low), both registers load their idle state: `rx_rdy_n`=1 and `tx_rdy_n`=0.
- R2: Each output takes, on a rising clock edge, the value implied by the inputs sampled at that edge. A change in the inputs does not reach the pins before the next rising edge.
- R3: With `fifo_en`=0, `rx_rdy_n` is 0 when `rx_count` is nonzero (a byte is held) and 1 when `rx_count` is 0.
- R4: With `fifo_en`=0, `tx_rdy_n` is 0 when `tx_count` is 0 (holding register empty) and 1 otherwise.
- R5: With `fifo_en`=1 and `dma_sel`=0, `rx_rdy_n` is 0 when `rx_count` is at least 1 and 1 when it is 0.
- R6: With `fifo_en`=1 and `dma_sel`=0, `tx_rdy_n` is 0 only when `tx_count` is 0 and 1 for any nonzero count.
- R7: While `fifo_en`=0, `dma_sel`, `rx_trig_hit` and `rx_timeout` have no effect on either pin.
- R8: In burst mode (`fifo_en`=1, `dma_sel`=1), a cycle with `rx_trig_hit`=1 and a nonzero `rx_count` drives `rx_rdy_n` to 0.
- R9: In burst mode, a cycle with `rx_timeout`=1 and a nonzero `rx_count` drives `rx_rdy_n` to 0.
- R10: In burst mode, while `rx_count` is nonzero and neither trigger nor timeout is present, `rx_rdy_n` keeps its previous value. It stays 0 while the buffer drains and stays 1 while the buffer fills below the trigger.
- R11: In burst mode, `rx_rdy_n` goes to 1 when `rx_count` is 0. An empty buffer takes priority over the trigger and timeout flags.
- R12: In burst mode, `tx_rdy_n` is 0 while `tx_count` is below `tx_capacity` and 1 when `tx_count` is equal to or greater than `tx_capacity`.
- R13: On the first cycle after the mode changes into burst mode, the hysteresis restarts: with data present and no trigger or timeout, `rx_rdy_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Buffers enabled |
| dma_sel | input | 1 | Burst-transfer mode select (effective only with fifo_en) |
| rx_count | input | CNT_W | Receive buffer occupancy |
| rx_trig_hit | input | 1 | Receive occupancy has reached the trigger level |
| rx_timeout | input | 1 | Receive timeout event |
| tx_count | input | CNT_W | Transmit buffer occupancy |
| tx_capacity | input | CNT_W | Transmit buffer depth in use |
| rx_rdy_n | output | 1 | Active-low receive service request |
| tx_rdy_n | output | 1 | Active-low transmit service request |

## Verification
The only internal state is the registered pins and the registered previous mode. A wrong hysteresis bit shows as a receive pin that stays asserted after a partial read, or one that asserts before the trigger. A wrong stored mode shows as a stale low pin on the first cycle after a switch into burst mode. Each of these faults is visible on the pin one clock after the input that should have resolved it. The bench therefore walks sequences that fill, drain and switch modes, and checks every cycle.

// File: rtl/rdy_pkg.sv
// Shared types for the ready-pin generator.
// Assumes: nothing beyond the two mode bits.
package rdy_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,  // buffers off: single holding register
        MODE_FIFO  = 2'd1,  // buffers on, single-transfer requests
        MODE_BURST = 2'd2   // buffers on, burst-transfer requests
    } rdy_mode_e;
endpackage

// File: rtl/rdy_mode_dec.sv
// Decodes the two mode bits into the effective mode and keeps the mode of
// the previous cycle, so the receive unit knows whether its hysteresis
// state belongs to the current mode.
// Assumes: dma_sel is meaningless while fifo_en is low.
module rdy_mode_dec
    import rdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    input  logic      dma_sel,
    output rdy_mode_e mode,
    output logic      burst_held
);
    rdy_mode_e mode_q;

    // Effective mode: the DMA bit counts only while buffers are enabled.
    always_comb begin
        if (!fifo_en)      mode = MODE_PLAIN;
        else if (dma_sel)  mode = MODE_BURST;
        else               mode = MODE_FIFO;
    end

    // Remember last cycle's mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PLAIN;
        else        mode_q <= mode;
    end

    // True when burst mode was already in force on the previous cycle.
    assign burst_held = (mode == MODE_BURST) && (mode_q == MODE_BURST);

    // R7: with buffers off, the decoded mode is never burst.
    a_r7_plain_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> mode == MODE_PLAIN);
endmodule

// File: rtl/rdy_rx_unit.sv
// Drives the registered active-low receive request pin.
// In burst mode the pin register doubles as the hysteresis state.
// Assumes: rx_trig_hit and rx_timeout are single-cycle-valid flags from
// the neighbouring trigger and timeout logic.
module rdy_rx_unit
    import rdy_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rdy_mode_e        mode,
    input  logic             burst_held,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_trig_hit,
    input  logic             rx_timeout,
    output logic             rx_rdy_n
);
    logic has_data;
    logic fire;
    logic next_n;

    assign has_data = (rx_count != '0);
    assign fire     = rx_trig_hit || rx_timeout;

    // Next pin value by mode; burst mode keeps state between events.
    always_comb begin
        unique case (mode)
            MODE_BURST: begin
                if (!has_data)       next_n = 1'b1;
                else if (fire)       next_n = 1'b0;
                else if (burst_held) next_n = rx_rdy_n;
                else                 next_n = 1'b1;
            end
            default:                 next_n = !has_data;
        endcase
    end

    // Pin register, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_rdy_n <= 1'b1;
        else        rx_rdy_n <= next_n;
    end

    // R3/R5: outside burst mode, an empty buffer gives a high pin.
    a_r5_empty_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BURST && !has_data) |=> rx_rdy_n);
    // R11: in burst mode, empty wins over every event.
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && !has_data) |=> rx_rdy_n);
    // R8/R9: in burst mode, an event with data asserts the pin.
    a_r8_assert_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && has_data && fire) |=> !rx_rdy_n);
    // R10: in burst mode, no event and data present keeps the pin.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_held && has_data && !fire) |=> $stable(rx_rdy_n));
    // R13: entering burst mode without an event starts high.
    a_r13_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && !burst_held && !fire) |=> rx_rdy_n);
endmodule

// File: rtl/rdy_tx_unit.sv
// Drives the registered active-low transmit request pin.
// Assumes: tx_capacity is nonzero and tx_count never exceeds it.
module rdy_tx_unit
    import rdy_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rdy_mode_e        mode,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_capacity,
    output logic             tx_rdy_n
);
    logic next_n;

    // Burst mode asks for writes while space remains; otherwise only when drained.
    always_comb begin
        if (mode == MODE_BURST) next_n = (tx_count >= tx_capacity);
        else                    next_n = (tx_count != '0);
    end

    // Pin register, idle low (transmit side empty after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) tx_rdy_n <= 1'b0;
        else        tx_rdy_n <= next_n;
    end

    // R12: a full buffer in burst mode deasserts the request.
    a_r12_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && tx_count >= tx_capacity) |=> tx_rdy_n);
    // R4/R6: outside burst mode, an empty transmit side requests data.
    a_r6_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BURST && tx_count == '0) |=> !tx_rdy_n);
endmodule

// File: rtl/uart_dma_rdy.sv
// Top of the ready-pin generator for one UART channel: decodes the mode
// and drives the receive and transmit request pins, both registered.
// Assumes: occupancy counts are synchronous to clk.
module uart_dma_rdy
    import rdy_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_trig_hit,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_capacity,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n
);
    rdy_mode_e mode;
    logic      burst_held;

    rdy_mode_dec u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .dma_sel    (dma_sel),
        .mode       (mode),
        .burst_held (burst_held)
    );

    rdy_rx_unit #(.CNT_W(CNT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .burst_held  (burst_held),
        .rx_count    (rx_count),
        .rx_trig_hit (rx_trig_hit),
        .rx_timeout  (rx_timeout),
        .rx_rdy_n    (rx_rdy_n)
    );

    rdy_tx_unit #(.CNT_W(CNT_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .tx_count    (tx_count),
        .tx_capacity (tx_capacity),
        .tx_rdy_n    (tx_rdy_n)
    );

    // R1: the cycle after reset shows the idle pin levels.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (rx_rdy_n && !tx_rdy_n));
endmodule

// File: tb/uart_dma_rdy_tb.sv
`timescale 1ns/1ps
module uart_dma_rdy_tb;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, dma_sel = 1'b0, rx_trig_hit = 1'b0, rx_timeout = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0, tx_capacity = 5'd16;
    logic rx_rdy_n, tx_rdy_n;
    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    uart_dma_rdy #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_sel(dma_sel),
        .rx_count(rx_count), .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout),
        .tx_count(tx_count), .tx_capacity(tx_capacity),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    typedef struct packed {
        logic       fe, dm;
        logic [4:0] rxc;
        logic       trig, tmo;
        logic [4:0] txc, cap;
        logic       erx, etx;
        logic [3:0] req;
    } vec_t;

    // Walked in order: burst-mode rows depend on the rows before them.
    localparam vec_t VECS [21] = '{
        '{1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 5'd16,1'b1,1'b0,4'd3},  // R3 R4 empty
        '{1'b0,1'b0,5'd1, 1'b0,1'b0,5'd1, 5'd16,1'b0,1'b1,4'd3},  // R3 R4 held
        '{1'b0,1'b1,5'd1, 1'b0,1'b0,5'd16,5'd16,1'b0,1'b1,4'd7},  // R7 dma ignored
        '{1'b0,1'b1,5'd0, 1'b1,1'b1,5'd5, 5'd16,1'b1,1'b1,4'd7},  // R7 events ignored
        '{1'b1,1'b0,5'd3, 1'b0,1'b0,5'd0, 5'd16,1'b0,1'b0,4'd5},  // R5 R6
        '{1'b1,1'b0,5'd0, 1'b1,1'b0,5'd1, 5'd16,1'b1,1'b1,4'd6},  // R5 R6
        '{1'b1,1'b0,5'd16,1'b0,1'b0,5'd15,5'd16,1'b0,1'b1,4'd6},  // R6 not empty
        '{1'b1,1'b1,5'd3, 1'b0,1'b0,5'd0, 5'd16,1'b1,1'b0,4'd13}, // R13 enter burst
        '{1'b1,1'b1,5'd5, 1'b0,1'b0,5'd15,5'd16,1'b1,1'b0,4'd10}, // R10 fill below trig
        '{1'b1,1'b1,5'd8, 1'b1,1'b0,5'd16,5'd16,1'b0,1'b1,4'd8},  // R8 trigger, R12 full
        '{1'b1,1'b1,5'd6, 1'b0,1'b0,5'd16,5'd16,1'b0,1'b1,4'd10}, // R10 draining
        '{1'b1,1'b1,5'd1, 1'b0,1'b0,5'd3, 5'd16,1'b0,1'b0,4'd10}, // R10 last byte
        '{1'b1,1'b1,5'd0, 1'b0,1'b0,5'd3, 5'd16,1'b1,1'b0,4'd11}, // R11 release
        '{1'b1,1'b1,5'd2, 1'b0,1'b0,5'd3, 5'd16,1'b1,1'b0,4'd10}, // R10 stays high
        '{1'b1,1'b1,5'd2, 1'b0,1'b1,5'd3, 5'd16,1'b0,1'b0,4'd9},  // R9 timeout
        '{1'b1,1'b1,5'd0, 1'b1,1'b1,5'd3, 5'd16,1'b1,1'b0,4'd11}, // R11 empty wins
        '{1'b1,1'b1,5'd4, 1'b1,1'b0,5'd8, 5'd8, 1'b0,1'b1,4'd12}, // R12 small capacity
        '{1'b1,1'b1,5'd4, 1'b0,1'b0,5'd7, 5'd8, 1'b0,1'b0,4'd12}, // R12 one free
        '{1'b1,1'b0,5'd4, 1'b0,1'b0,5'd7, 5'd8, 1'b0,1'b1,4'd5},  // R5 leave burst
        '{1'b1,1'b1,5'd4, 1'b0,1'b0,5'd7, 5'd8, 1'b1,1'b0,4'd13}, // R13 re-enter
        '{1'b0,1'b1,5'd1, 1'b1,1'b0,5'd8, 5'd8, 1'b0,1'b1,4'd7}   // R7 off again
    };

    task automatic check(input logic act, input logic exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fifo_en = v.fe; dma_sel = v.dm; rx_count = v.rxc; rx_trig_hit = v.trig;
        rx_timeout = v.tmo; tx_count = v.txc; tx_capacity = v.cap;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(rx_rdy_n, 1'b1, 1, "rx after reset");  // R1
        check(tx_rdy_n, 1'b0, 1, "tx after reset");  // R1
        rst_n = 1'b1;
        for (int i = 0; i < 21; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check(rx_rdy_n, VECS[i].erx, int'(VECS[i].req), $sformatf("row %0d rx", i));
            check(tx_rdy_n, VECS[i].etx, int'(VECS[i].req), $sformatf("row %0d tx", i));
        end
        // R2: new inputs do not reach the pins before the next edge.
        drive('{1'b1,1'b0,5'd0,1'b0,1'b0,5'd0,5'd16,1'b0,1'b0,4'd2});
        #1;
        check(rx_rdy_n, 1'b0, 2, "rx before edge");
        check(tx_rdy_n, 1'b1, 2, "tx before edge");
        @(posedge clk); @(negedge clk);
        check(rx_rdy_n, 1'b1, 2, "rx after edge");
        check(tx_rdy_n, 1'b0, 2, "tx after edge");
        // R1: reset in the middle of a burst clears the held request.
        drive('{1'b1,1'b1,5'd9,1'b1,1'b0,5'd16,5'd16,1'b0,1'b1,4'd1});
        @(posedge clk); @(negedge clk);
        check(rx_rdy_n, 1'b0, 8, "burst armed");  // R8
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rx_rdy_n, 1'b1, 1, "rx mid-run reset");
        check(tx_rdy_n, 1'b0, 1, "tx mid-run reset");
        // R13: after reset, data without an event stays high in burst mode.
        rst_n = 1'b1;
        rx_trig_hit = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rx_rdy_n, 1'b1, 13, "post-reset burst entry");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule